// File: doc/BRIEF.md
# Status Flag and Bit Manipulation Unit

This block holds the 8-bit status register of a small 32-bit register machine and carries out the instructions that act on it. The ALU writes its zero, carry and negative results into it, with one write enable per flag. Software-visible user flags in the upper nibble can change only through two mask operations, set and clear. When a set or clear names the zero register, its 8-bit constant is a mask applied to the status register. When it names any other register, the low five bits of the constant pick a single bit of the 32-bit register operand to force high or low. The unit returns the modified value, and the surrounding datapath writes it back.

The same unit decides conditional branches. A branch names one status bit and fires either when that bit is 1 or when it is 0. The target is the address that follows the 2-byte branch plus twice the sign-extended 8-bit offset, wrapped to 24 bits. The status register updates on the clock edge. Register results, branch decisions and targets are combinational, and the branch logic reads the status value held before the edge.

Top module: `status_flag_unit`

## Requirements
- R1: While `rstN` is low the status register is forced to 8'h00, and it reads 8'h00 on the first cycle after release.
- R2: With `opSel`=1 (ALU update), status bit i (Z=bit 0, C=bit 1, N=bit 2) takes `aluFlags[i]` at the next rising edge if `aluWe[i]` is 1, and keeps its value otherwise.
- R3: An ALU update never changes status bits 7..4 (user flags).
- R4: Status bit 3 always reads 0. No operation can set it, and a branch that tests it sees 0.
- R5: `opSel`=2 (set) with `targetIsZero`=1 ORs `immVal` into the status register at the next edge (bit 3 excepted).
- R6: `opSel`=3 (clear) with `targetIsZero`=1 clears every status bit whose `immVal` bit is 1 at the next edge.
- R7: `opSel`=2 or 3 with `targetIsZero`=0 drives `regOut` combinationally as `regIn` with bit `immVal[4:0]` set (2) or cleared (3), every other bit unchanged, `immVal[7:5]` ignored, and the status register unchanged.
- R8: For every other operation, and for set/clear aimed at the zero register, `regOut` equals `regIn`.
- R9: `opSel`=4 asserts `branchTaken` when status bit `bitSel` is 1, and `opSel`=5 asserts it when that bit is 0, using the value held before the edge. For codes 0, 1, 2, 3, 6 and 7 `branchTaken` is 0.
- R10: `branchTarget` = (`pcIn` + 2 + 2*signext(`immVal`)) mod 2^24 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opSel | input | 3 | Operation code (0 idle, 1 ALU, 2 set, 3 clear, 4 branch-if-1, 5 branch-if-0) |
| targetIsZero | input | 1 | Set/clear is aimed at the zero register (mask form) |
| immVal | input | 8 | Mask, bit index (low 5 bits) or signed branch offset |
| bitSel | input | 3 | Status bit tested by a branch |
| regIn | input | 32 | Register operand for single-bit set/clear |
| pcIn | input | 24 | Address of the current branch instruction |
| aluFlags | input | 3 | ALU results {N, C, Z} |
| aluWe | input | 3 | Per-flag write enables {N, C, Z} |
| statusOut | output | 8 | Current status register |
| regOut | output | 32 | Register operand after set/clear |
| branchTaken | output | 1 | Branch condition met |
| branchTarget | output | 24 | Computed branch target |

## Verification
The bench targets the reserved bit 3. A design that stores it would show 1 after a full set mask, and a branch-if-0 on it would stop firing. A partially enabled ALU write must leave the disabled flags and the whole user nibble untouched, which catches a design that writes all eight bits. The branch offset is exercised at both extremes and across the 24-bit wrap, so a missing shift, a zero extension or a 32-bit carry changes the target. Bit index 31 and an index constant with junk in its upper bits expose a truncated or mis-sliced shift amount.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_ALU   = 3'd1,
    OP_SET   = 3'd2,
    OP_CLR   = 3'd3,
    OP_BRSET = 3'd4,
    OP_BRCLR = 3'd5
  } sfuOp_e;

  typedef struct packed {
    logic aluWr;
    logic srSet;
    logic srClr;
    logic regSet;
    logic regClr;
    logic brTest;
    logic brWhenSet;
  } sfuStrobe_t;

endpackage

// File: rtl/sfu_ctrl.sv
module sfu_ctrl
  import sfu_pkg::*;
(
  input  logic [2:0] opSel,
  input  logic       targetIsZero,
  output sfuStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    unique case (opSel)
      OP_ALU:   strobe.aluWr = 1'b1;
      OP_SET: begin
        strobe.srSet  = targetIsZero;
        strobe.regSet = !targetIsZero;
      end
      OP_CLR: begin
        strobe.srClr  = targetIsZero;
        strobe.regClr = !targetIsZero;
      end
      OP_BRSET: begin
        strobe.brTest    = 1'b1;
        strobe.brWhenSet = 1'b1;
      end
      OP_BRCLR: strobe.brTest = 1'b1;
      default:  strobe = '0;
    endcase
  end

endmodule

// File: rtl/sfu_datapath.sv
module sfu_datapath
  import sfu_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PC_W        = 24,
  parameter int SR_W        = 8,
  parameter int OFF_W       = 8,
  parameter int NUM_ALU     = 3,
  parameter int RSVD_BIT    = 3,
  parameter int USER_LO     = 4,
  parameter int INSTR_BYTES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sfuStrobe_t               strobe,
  input  logic [OFF_W-1:0]         immVal,
  input  logic [$clog2(SR_W)-1:0]  bitSel,
  input  logic [DATA_W-1:0]        regIn,
  input  logic [PC_W-1:0]          pcIn,
  input  logic [NUM_ALU-1:0]       aluFlags,
  input  logic [NUM_ALU-1:0]       aluWe,
  output logic [SR_W-1:0]          statusOut,
  output logic [DATA_W-1:0]        regOut,
  output logic                     branchTaken,
  output logic [PC_W-1:0]          branchTarget
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [SR_W-1:0] WR_MASK = ~(SR_W'(1) << RSVD_BIT);
  localparam int EXT_W = PC_W - OFF_W - 1;

  logic [SR_W-1:0]   statusQ;
  logic [SR_W-1:0]   aluMerged;
  logic [SR_W-1:0]   statusNext;
  logic [SR_W-1:0]   maskEff;
  logic [DATA_W-1:0] bitMask;
  logic [PC_W-1:0]   offExt;

  assign maskEff = immVal[SR_W-1:0] & WR_MASK;

  // per-flag ALU merge, one slice per ALU flag
  genvar gi;
  generate
    for (gi = 0; gi < SR_W; gi++) begin : gAluMerge
      if (gi < NUM_ALU) begin : gFlag
        assign aluMerged[gi] = aluWe[gi] ? aluFlags[gi] : statusQ[gi];
      end else begin : gKeep
        assign aluMerged[gi] = statusQ[gi];
      end
    end
  endgenerate

  always_comb begin
    statusNext = statusQ;
    if (strobe.aluWr) statusNext = aluMerged;
    if (strobe.srSet) statusNext = statusQ | maskEff;
    if (strobe.srClr) statusNext = statusQ & ~maskEff;
    statusNext = statusNext & WR_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= statusNext;
  end

  assign statusOut = statusQ;

  // single-bit register manipulation
  assign bitMask = DATA_W'(1) << immVal[IDX_W-1:0];

  always_comb begin
    regOut = regIn;
    if (strobe.regSet) regOut = regIn | bitMask;
    if (strobe.regClr) regOut = regIn & ~bitMask;
  end

  // branch condition and target
  assign branchTaken = strobe.brTest && (statusQ[bitSel] == strobe.brWhenSet);
  assign offExt = {{EXT_W{immVal[OFF_W-1]}}, immVal, 1'b0};
  assign branchTarget = pcIn + PC_W'(INSTR_BYTES) + offExt;

  AST_USER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.aluWr |=> $stable(statusQ[SR_W-1:USER_LO])); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[RSVD_BIT] == 1'b0); // R4
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.srSet |=> ((statusQ & $past(maskEff)) == $past(maskEff))); // R5
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.srClr |=> ((statusQ & $past(maskEff)) == '0)); // R6
  AST_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.regSet || strobe.regClr) |-> ($countones(regOut ^ regIn) <= 1)); // R7
  AST_REG_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.regSet || strobe.regClr) |-> (regOut == regIn)); // R8
  AST_NO_BRANCH: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.brTest |-> !branchTaken); // R9
  AST_SR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.regSet || strobe.regClr || strobe.brTest) |=> $stable(statusQ)); // R7

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sfu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PC_W    = 24,
  parameter int SR_W    = 8,
  parameter int OFF_W   = 8,
  parameter int NUM_ALU = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2:0]              opSel,
  input  logic                    targetIsZero,
  input  logic [OFF_W-1:0]        immVal,
  input  logic [$clog2(SR_W)-1:0] bitSel,
  input  logic [DATA_W-1:0]       regIn,
  input  logic [PC_W-1:0]         pcIn,
  input  logic [NUM_ALU-1:0]      aluFlags,
  input  logic [NUM_ALU-1:0]      aluWe,
  output logic [SR_W-1:0]         statusOut,
  output logic [DATA_W-1:0]       regOut,
  output logic                    branchTaken,
  output logic [PC_W-1:0]         branchTarget
);

  sfuStrobe_t strobe;

  sfu_ctrl u_ctrl (
    .opSel        (opSel),
    .targetIsZero (targetIsZero),
    .strobe       (strobe)
  );

  sfu_datapath #(
    .DATA_W  (DATA_W),
    .PC_W    (PC_W),
    .SR_W    (SR_W),
    .OFF_W   (OFF_W),
    .NUM_ALU (NUM_ALU)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .immVal       (immVal),
    .bitSel       (bitSel),
    .regIn        (regIn),
    .pcIn         (pcIn),
    .aluFlags     (aluFlags),
    .aluWe        (aluWe),
    .statusOut    (statusOut),
    .regOut       (regOut),
    .branchTaken  (branchTaken),
    .branchTarget (branchTarget)
  );

endmodule

// File: tb/status_flag_unit_tb.sv
`timescale 1ns/1ps
module status_flag_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  opSel;
  logic        targetIsZero;
  logic [7:0]  immVal;
  logic [2:0]  bitSel;
  logic [31:0] regIn;
  logic [23:0] pcIn;
  logic [2:0]  aluFlags;
  logic [2:0]  aluWe;
  logic [7:0]  statusOut;
  logic [31:0] regOut;
  logic        branchTaken;
  logic [23:0] branchTarget;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  status_flag_unit dut_i (
    .clk(clk), .rstN(rstN), .opSel(opSel), .targetIsZero(targetIsZero),
    .immVal(immVal), .bitSel(bitSel), .regIn(regIn), .pcIn(pcIn),
    .aluFlags(aluFlags), .aluWe(aluWe), .statusOut(statusOut),
    .regOut(regOut), .branchTaken(branchTaken), .branchTarget(branchTarget)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        tz;
    logic [7:0]  imm;
    logic [2:0]  bsel;
    logic [31:0] rv;
    logic [23:0] pc;
    logic [2:0]  af;
    logic [2:0]  awe;
    logic [31:0] expReg;
    logic        expTaken;
    logic [23:0] expTgt;
    logic [7:0]  expSr;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 1'b0, 8'h00, 3'd0, 32'h12345678, 24'h000100, 3'b111, 3'b101, 32'h12345678, 1'b0, 24'h000102, 8'h05},
    '{3'd2, 1'b1, 8'hFF, 3'd0, 32'h00000001, 24'h000100, 3'b000, 3'b000, 32'h00000001, 1'b0, 24'h000100, 8'hF7},
    '{3'd1, 1'b0, 8'h00, 3'd0, 32'h00000002, 24'h000000, 3'b000, 3'b111, 32'h00000002, 1'b0, 24'h000002, 8'hF0},
    '{3'd3, 1'b1, 8'h5A, 3'd0, 32'h00000003, 24'h000000, 3'b000, 3'b000, 32'h00000003, 1'b0, 24'h0000B6, 8'hA0},
    '{3'd2, 1'b0, 8'h1F, 3'd0, 32'h00000000, 24'h000000, 3'b000, 3'b000, 32'h80000000, 1'b0, 24'h000040, 8'hA0},
    '{3'd3, 1'b0, 8'hE3, 3'd0, 32'hFFFFFFFF, 24'h000000, 3'b000, 3'b000, 32'hFFFFFFF7, 1'b0, 24'hFFFFC8, 8'hA0},
    '{3'd4, 1'b0, 8'h7F, 3'd7, 32'h00000000, 24'hFFFFFE, 3'b000, 3'b000, 32'h00000000, 1'b1, 24'h0000FE, 8'hA0},
    '{3'd5, 1'b0, 8'h80, 3'd7, 32'h00000000, 24'h000010, 3'b000, 3'b000, 32'h00000000, 1'b0, 24'hFFFF12, 8'hA0},
    '{3'd5, 1'b0, 8'h00, 3'd3, 32'h00000000, 24'h000000, 3'b000, 3'b000, 32'h00000000, 1'b1, 24'h000002, 8'hA0},
    '{3'd4, 1'b0, 8'h10, 3'd5, 32'h00000000, 24'h123456, 3'b000, 3'b000, 32'h00000000, 1'b1, 24'h123478, 8'hA0},
    '{3'd1, 1'b0, 8'h00, 3'd0, 32'h00000000, 24'h000000, 3'b111, 3'b000, 32'h00000000, 1'b0, 24'h000002, 8'hA0},
    '{3'd2, 1'b1, 8'h08, 3'd0, 32'h00000000, 24'h000000, 3'b000, 3'b000, 32'h00000000, 1'b0, 24'h000012, 8'hA0},
    '{3'd1, 1'b0, 8'h00, 3'd0, 32'h00000000, 24'h000000, 3'b010, 3'b010, 32'h00000000, 1'b0, 24'h000002, 8'hA2},
    '{3'd6, 1'b0, 8'h00, 3'd1, 32'hDEADBEEF, 24'h000000, 3'b000, 3'b000, 32'hDEADBEEF, 1'b0, 24'h000002, 8'hA2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic tz, input logic [7:0] imm,
                       input logic [2:0] bs, input logic [31:0] rv, input logic [23:0] pc,
                       input logic [2:0] af, input logic [2:0] awe);
    @(negedge clk);
    opSel = op; targetIsZero = tz; immVal = imm; bitSel = bs;
    regIn = rv; pcIn = pc; aluFlags = af; aluWe = awe;
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    opSel = 3'd0; targetIsZero = 1'b0; immVal = '0; bitSel = '0;
    regIn = '0; pcIn = '0; aluFlags = '0; aluWe = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset status", {24'h0, statusOut}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 status after release", {24'h0, statusOut}, 32'h0);
    chk("R9 idle no branch", {31'h0, branchTaken}, 32'h0);

    // vector table: combinational outputs before edge, status after edge
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].tz, VECS[i].imm, VECS[i].bsel, VECS[i].rv,
            VECS[i].pc, VECS[i].af, VECS[i].awe);
      chk("R7/R8 regOut", regOut, VECS[i].expReg);
      chk("R9 branchTaken", {31'h0, branchTaken}, {31'h0, VECS[i].expTaken});
      chk("R10 branchTarget", {8'h0, branchTarget}, {8'h0, VECS[i].expTgt});
      @(posedge clk);
      #1;
      chk("R2/R3/R4/R5/R6 status", {24'h0, statusOut}, {24'h0, VECS[i].expSr});
    end

    // R7: every bit index on a zero register and on an all-ones register
    for (int k = 0; k < 32; k++) begin
      drive(3'd2, 1'b0, 8'(k), 3'd0, 32'h0, 24'h0, 3'b000, 3'b000);
      chk("R7 set index", regOut, 32'h1 << k);
      drive(3'd3, 1'b0, 8'(k) | 8'hA0, 3'd0, 32'hFFFFFFFF, 24'h0, 3'b000, 3'b000);
      chk("R7 clear index", regOut, ~(32'h1 << k));
    end
    #3;
    chk("R7 status untouched", {24'h0, statusOut}, 32'hA2);

    // R8: mask-form set leaves regOut equal to regIn
    drive(3'd2, 1'b1, 8'h01, 3'd0, 32'h0F0F0F0F, 24'h0, 3'b000, 3'b000);
    chk("R8 mask form pass", regOut, 32'h0F0F0F0F);
    @(posedge clk); #1;
    chk("R5 set Z", {24'h0, statusOut}, 32'hA3);

    // R9: branch on ALU flag Z, both forms; opSel 7 idle
    drive(3'd4, 1'b0, 8'h00, 3'd0, 32'h0, 24'h0, 3'b000, 3'b000);
    chk("R9 branch-if-1 on Z", {31'h0, branchTaken}, 32'h1);
    drive(3'd5, 1'b0, 8'h00, 3'd0, 32'h0, 24'h0, 3'b000, 3'b000);
    chk("R9 branch-if-0 on Z", {31'h0, branchTaken}, 32'h0);
    drive(3'd7, 1'b0, 8'h00, 3'd0, 32'h0, 24'h0, 3'b000, 3'b000);
    chk("R9 code 7 no branch", {31'h0, branchTaken}, 32'h0);

    // R6 / R3: clear all user flags, ALU full write, user stays clear
    drive(3'd3, 1'b1, 8'hF0, 3'd0, 32'h0, 24'h0, 3'b000, 3'b000);
    @(posedge clk); #1;
    chk("R6 clear user", {24'h0, statusOut}, 32'h03);
    drive(3'd1, 1'b0, 8'h00, 3'd0, 32'h0, 24'h0, 3'b100, 3'b111);
    @(posedge clk); #1;
    chk("R2 ALU full write", {24'h0, statusOut}, 32'h04);

    // R1: reset in mid-run
    drive(3'd2, 1'b1, 8'hFF, 3'd0, 32'h0, 24'h0, 3'b000, 3'b000);
    @(posedge clk); #1;
    chk("R5 set all", {24'h0, statusOut}, 32'hF7);
    @(negedge clk);
    rstN = 1'b0;
    opSel = 3'd0;
    @(posedge clk); #1;
    chk("R1 mid-run reset", {24'h0, statusOut}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule